// File: doc/BRIEF.md
# Microcoded Multi-Cycle Instruction Sequencer

This block is the control path that sits beside a register array whose rows each carry a small bit-serial adder/logic cell. A fetch stage presents the program counter to a simple instruction memory and keeps the returned word in a holding register. A decode stage pulls out the register indexes and the immediate, and picks a start address in a small microcode ROM. The execute stage then plays that microcode out, one control word per clock. Each word drives the array's one-hot controls: the operation of the local cell, the source on the read bus and the write target.

Simple register and immediate operations finish in one word. Subtraction and conditional branches reuse the same add/logic hardware over several words. While a sequence is running, the front end is held. The word that carries the final-step flag lets the held instruction move into execute on the next clock. A branch samples a zero indication from the array on its resolve step. When the branch is taken, the PC is reloaded with the branch target and the instruction already fetched is discarded.

Top module: `useq_core`

## Requirements
- R1: While reset is asserted the fetch address is 0, no instruction is in execute and the control word is all zero. The first instruction to reach execute after reset is the one fetched from address 0.
- R2: The fetch address steps by 4 on each fetch. It holds its value while the execute stage is stalled. With an instruction at 0 still executing, the fetch address stays 8 for every step.
- R3: For the instruction in execute, the destination index comes from instruction bits 11:7. The immediate depends on the opcode: a sign-extended 12-bit value from bits 31:20 (the default), a 20-bit upper value from bits 31:12 followed by 12 zero bits (opcode 0110111), or a sign-extended branch offset (opcode 1100011).
- R4: Step counts are fixed per class. Register and immediate ADD/XOR/AND/OR, the upper-immediate load and the no-operation take 1 step. SUB (funct7 0100000) takes 3 steps. BEQ and BNE take 4 steps.
- R5: The control word is 14 bits wide. Bits 3:0 select the cell operation one-hot (bit0 add, bit1 xor, bit2 and, bit3 or). Bits 6:4 select the read-bus source one-hot (bit4 second register, bit5 immediate, bit6 scratch row). Bits 8:7 select the write target one-hot (bit7 destination, bit8 scratch). The single bits are: bit9 invert bus, bit10 carry-in, bit11 branch resolve, bit12 last step, bit13 mask the row operand. A register ADD gives 0x1091, an immediate ADD gives 0x10A1, and the upper-immediate load gives 0x30A1.
- R6: The cycle after a step that carries the last-step flag, the next sequential instruction is in execute, unless a branch redirect happens on that step. One-step instructions therefore issue back to back, one per cycle.
- R7: Any opcode, funct3 or funct7 combination outside the supported set runs as a single no-operation word 0x1000.
- R8: On the resolve step, BEQ is taken when the zero input is high and BNE is taken when it is low. A taken branch loads the PC with the branch's own address plus its offset and drops the fetched fall-through instruction. The target then reaches execute 3 cycles after the resolve step. A branch that is not taken behaves as in R6.
- R9: When no instruction is in execute the control word is zero. In every word, the operation, bus-source and write-target fields each have at most one bit set.
- R10: The zero input has no effect outside a branch resolve step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | PC_W | Fetch address (PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| arr_zero | input | 1 | Zero indication from the array, used on the resolve step |
| ex_valid | output | 1 | An instruction occupies the execute stage |
| ex_pc | output | PC_W | Address of the executing instruction |
| ex_rs1 | output | 5 | First source index, selects the computing row |
| ex_rs2 | output | 5 | Second source index, drives the read bus |
| ex_rd | output | 5 | Destination index |
| ex_imm | output | XLEN | Decoded immediate |
| ex_ctl | output | 14 | Current microcode control word |

## Verification
The assertions assume that the instruction memory returns a defined word in the same cycle for any address the block presents. They also assume that the zero input is a plain level sampled only at clock edges. The bench models the memory as a combinational lookup that is zero-filled outside the loaded program, so every fetch sees a known word. It changes the zero input only at falling edges, including a run where it toggles every cycle during non-branch code.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ILEN = 32;
    localparam int RI_W = 5;
    localparam int UA_W = 5;
    localparam int CW_W = 14;
    localparam int LAST_BIT = 12;
    localparam int BR_BIT   = 11;

    typedef logic [UA_W-1:0] uaddr_t;

    typedef struct packed {
        logic       row_mask;
        logic       last;
        logic       br_eval;
        logic       cin;
        logic       inv;
        logic [1:0] wr_sel;
        logic [2:0] bus_sel;
        logic [3:0] fa_op;
    } uword_t;

    localparam logic [3:0] FA_NONE = 4'b0000;
    localparam logic [3:0] FA_ADD  = 4'b0001;
    localparam logic [3:0] FA_XOR  = 4'b0010;
    localparam logic [3:0] FA_AND  = 4'b0100;
    localparam logic [3:0] FA_OR   = 4'b1000;

    localparam logic [2:0] BUS_NONE = 3'b000;
    localparam logic [2:0] BUS_RS2  = 3'b001;
    localparam logic [2:0] BUS_IMM  = 3'b010;
    localparam logic [2:0] BUS_TMP  = 3'b100;

    localparam logic [1:0] WR_NONE = 2'b00;
    localparam logic [1:0] WR_RD   = 2'b01;
    localparam logic [1:0] WR_TMP  = 2'b10;

    localparam uaddr_t UA_NOP  = 5'd0;
    localparam uaddr_t UA_ADD  = 5'd1;
    localparam uaddr_t UA_XOR  = 5'd2;
    localparam uaddr_t UA_AND  = 5'd3;
    localparam uaddr_t UA_OR   = 5'd4;
    localparam uaddr_t UA_ADDI = 5'd5;
    localparam uaddr_t UA_XORI = 5'd6;
    localparam uaddr_t UA_ANDI = 5'd7;
    localparam uaddr_t UA_ORI  = 5'd8;
    localparam uaddr_t UA_LUI  = 5'd9;
    localparam uaddr_t UA_SUB0 = 5'd10;
    localparam uaddr_t UA_SUB1 = 5'd11;
    localparam uaddr_t UA_SUB2 = 5'd12;
    localparam uaddr_t UA_BR0  = 5'd13;
    localparam uaddr_t UA_BR1  = 5'd14;
    localparam uaddr_t UA_BR2  = 5'd15;
    localparam uaddr_t UA_BR3  = 5'd16;

    localparam logic [6:0] OPC_REG = 7'b0110011;
    localparam logic [6:0] OPC_IMM = 7'b0010011;
    localparam logic [6:0] OPC_LUI = 7'b0110111;
    localparam logic [6:0] OPC_BR  = 7'b1100011;

    function automatic uword_t mk_word(
        input logic [3:0] op,
        input logic [2:0] bus,
        input logic [1:0] wr,
        input logic       inv,
        input logic       cin,
        input logic       br,
        input logic       last,
        input logic       mask
    );
        uword_t w;
        w.fa_op    = op;
        w.bus_sel  = bus;
        w.wr_sel   = wr;
        w.inv      = inv;
        w.cin      = cin;
        w.br_eval  = br;
        w.last     = last;
        w.row_mask = mask;
        return w;
    endfunction

endpackage

// File: rtl/useq_urom.sv
module useq_urom
    import useq_pkg::*;
(
    input  uaddr_t addr_i,
    output uword_t word_o
);

    always_comb begin
        case (addr_i)
            UA_ADD:  word_o = mk_word(FA_ADD, BUS_RS2, WR_RD,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            UA_XOR:  word_o = mk_word(FA_XOR, BUS_RS2, WR_RD,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            UA_AND:  word_o = mk_word(FA_AND, BUS_RS2, WR_RD,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            UA_OR:   word_o = mk_word(FA_OR,  BUS_RS2, WR_RD,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            UA_ADDI: word_o = mk_word(FA_ADD, BUS_IMM, WR_RD,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            UA_XORI: word_o = mk_word(FA_XOR, BUS_IMM, WR_RD,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            UA_ANDI: word_o = mk_word(FA_AND, BUS_IMM, WR_RD,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            UA_ORI:  word_o = mk_word(FA_OR,  BUS_IMM, WR_RD,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            // immediate passes straight through: row operand masked
            UA_LUI:  word_o = mk_word(FA_ADD, BUS_IMM, WR_RD,   1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
            // subtract: scratch = ~rs2, scratch += 1, rd = rs1 + scratch
            UA_SUB0: word_o = mk_word(FA_ADD, BUS_RS2, WR_TMP,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
            UA_SUB1: word_o = mk_word(FA_ADD, BUS_TMP, WR_TMP,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
            UA_SUB2: word_o = mk_word(FA_ADD, BUS_TMP, WR_RD,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            // compare: difference into scratch, fold passes, resolve on zero
            UA_BR0:  word_o = mk_word(FA_XOR, BUS_RS2, WR_TMP,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            UA_BR1:  word_o = mk_word(FA_OR,  BUS_TMP, WR_TMP,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            UA_BR2:  word_o = mk_word(FA_AND, BUS_TMP, WR_TMP,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            UA_BR3:  word_o = mk_word(FA_OR,  BUS_TMP, WR_NONE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
            default: word_o = mk_word(FA_NONE, BUS_NONE, WR_NONE, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        endcase
    end

endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0] instr_i,
    output logic [RI_W-1:0] rs1_o,
    output logic [RI_W-1:0] rs2_o,
    output logic [RI_W-1:0] rd_o,
    output logic [XLEN-1:0] imm_o,
    output uaddr_t          ua_o,
    output logic            inv_cond_o
);

    logic [6:0]      opc;
    logic [2:0]      f3;
    logic            f7_zero;
    logic            f7_sub;
    logic [ILEN-1:0] imm32;

    always_comb begin
        opc     = instr_i[6:0];
        f3      = instr_i[14:12];
        f7_zero = (instr_i[31:25] == 7'b0000000);
        f7_sub  = (instr_i[31:25] == 7'b0100000);
        rs1_o   = instr_i[19:15];
        rs2_o   = instr_i[24:20];
        rd_o    = instr_i[11:7];

        case (opc)
            OPC_LUI: imm32 = {instr_i[31:12], 12'b0};
            OPC_BR:  imm32 = {{20{instr_i[31]}}, instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
            default: imm32 = {{20{instr_i[31]}}, instr_i[31:20]};
        endcase
        imm_o = XLEN'($signed(imm32));

        ua_o       = UA_NOP;
        inv_cond_o = 1'b0;
        case (opc)
            OPC_REG: begin
                case (f3)
                    3'b000: begin
                        if (f7_zero)     ua_o = UA_ADD;
                        else if (f7_sub) ua_o = UA_SUB0;
                    end
                    3'b100:  if (f7_zero) ua_o = UA_XOR;
                    3'b110:  if (f7_zero) ua_o = UA_OR;
                    3'b111:  if (f7_zero) ua_o = UA_AND;
                    default: ua_o = UA_NOP;
                endcase
            end
            OPC_IMM: begin
                case (f3)
                    3'b000:  ua_o = UA_ADDI;
                    3'b100:  ua_o = UA_XORI;
                    3'b110:  ua_o = UA_ORI;
                    3'b111:  ua_o = UA_ANDI;
                    default: ua_o = UA_NOP;
                endcase
            end
            OPC_LUI: ua_o = UA_LUI;
            OPC_BR: begin
                if (f3[2:1] == 2'b00) begin
                    ua_o       = UA_BR0;
                    inv_cond_o = f3[0];
                end
            end
            default: ua_o = UA_NOP;
        endcase
    end

endmodule

// File: rtl/useq_fetch.sv
module useq_fetch
    import useq_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic            redir_i,
    input  logic [PC_W-1:0] redir_pc_i,
    input  logic [ILEN-1:0] imem_rdata_i,
    output logic [PC_W-1:0] imem_addr_o,
    output logic            dv_o,
    output logic [ILEN-1:0] instr_o,
    output logic [PC_W-1:0] ipc_o
);

    localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            dv;
        logic [ILEN-1:0] instr;
        logic [PC_W-1:0] ipc;
    } fstate_t;

    fstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (redir_i) begin
            st_d.pc = redir_pc_i;
            st_d.dv = 1'b0;
        end else if (!st_q.dv || take_i) begin
            st_d.pc    = st_q.pc + PC_STEP;
            st_d.dv    = 1'b1;
            st_d.instr = imem_rdata_i;
            st_d.ipc   = st_q.pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pc: RESET_PC, dv: 1'b0, instr: '0, ipc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_addr_o = st_q.pc;
    assign dv_o        = st_q.dv;
    assign instr_o     = st_q.instr;
    assign ipc_o       = st_q.ipc;

endmodule

// File: rtl/useq_exec.sv
module useq_exec
    import useq_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dv_i,
    input  logic [PC_W-1:0] dpc_i,
    input  logic [RI_W-1:0] drs1_i,
    input  logic [RI_W-1:0] drs2_i,
    input  logic [RI_W-1:0] drd_i,
    input  logic [XLEN-1:0] dimm_i,
    input  uaddr_t          dua_i,
    input  logic            dinv_i,
    input  uword_t          word_i,
    input  logic            arr_zero_i,
    output uaddr_t          upc_o,
    output logic            take_o,
    output logic            redir_o,
    output logic [PC_W-1:0] redir_pc_o,
    output logic            ex_valid_o,
    output logic [PC_W-1:0] ex_pc_o,
    output logic [RI_W-1:0] ex_rs1_o,
    output logic [RI_W-1:0] ex_rs2_o,
    output logic [RI_W-1:0] ex_rd_o,
    output logic [XLEN-1:0] ex_imm_o,
    output logic            ex_inv_o,
    output uword_t          ex_ctl_o
);

    typedef struct packed {
        logic            v;
        uaddr_t          upc;
        logic [PC_W-1:0] pc;
        logic [RI_W-1:0] rs1;
        logic [RI_W-1:0] rs2;
        logic [RI_W-1:0] rd;
        logic [XLEN-1:0] imm;
        logic            inv;
    } xstate_t;

    xstate_t st_d, st_q;
    logic    step_last;
    logic    taken;
    logic    take;

    always_comb begin
        step_last = st_q.v && word_i.last;
        taken     = st_q.v && word_i.br_eval && (arr_zero_i ^ st_q.inv);
        take      = (!st_q.v || step_last) && dv_i && !taken;

        st_d = st_q;
        if (st_q.v && !word_i.last) begin
            st_d.upc = st_q.upc + UA_W'(1);
        end else if (take) begin
            st_d.v   = 1'b1;
            st_d.upc = dua_i;
            st_d.pc  = dpc_i;
            st_d.rs1 = drs1_i;
            st_d.rs2 = drs2_i;
            st_d.rd  = drd_i;
            st_d.imm = dimm_i;
            st_d.inv = dinv_i;
        end else begin
            st_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upc_o      = st_q.upc;
    assign take_o     = take;
    assign redir_o    = taken;
    assign redir_pc_o = st_q.pc + PC_W'(st_q.imm);
    assign ex_valid_o = st_q.v;
    assign ex_pc_o    = st_q.pc;
    assign ex_rs1_o   = st_q.rs1;
    assign ex_rs2_o   = st_q.rs2;
    assign ex_rd_o    = st_q.rd;
    assign ex_imm_o   = st_q.imm;
    assign ex_inv_o   = st_q.inv;
    assign ex_ctl_o   = st_q.v ? word_i : '0;

endmodule

// File: rtl/useq_core.sv
module useq_core
    import useq_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] imem_addr,
    input  logic [ILEN-1:0] imem_rdata,
    input  logic            arr_zero,
    output logic            ex_valid,
    output logic [PC_W-1:0] ex_pc,
    output logic [RI_W-1:0] ex_rs1,
    output logic [RI_W-1:0] ex_rs2,
    output logic [RI_W-1:0] ex_rd,
    output logic [XLEN-1:0] ex_imm,
    output logic [CW_W-1:0] ex_ctl
);

    logic            f_dv;
    logic [ILEN-1:0] f_instr;
    logic [PC_W-1:0] f_ipc;
    logic            take;
    logic            redir;
    logic [PC_W-1:0] redir_pc;
    logic [RI_W-1:0] d_rs1, d_rs2, d_rd;
    logic [XLEN-1:0] d_imm;
    uaddr_t          d_ua;
    logic            d_inv;
    uaddr_t          upc;
    uword_t          rom_word;
    uword_t          ctl_word;
    logic            x_inv;

    useq_fetch #(.PC_W(PC_W)) fetch_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_i       (take),
        .redir_i      (redir),
        .redir_pc_i   (redir_pc),
        .imem_rdata_i (imem_rdata),
        .imem_addr_o  (imem_addr),
        .dv_o         (f_dv),
        .instr_o      (f_instr),
        .ipc_o        (f_ipc)
    );

    useq_decode #(.XLEN(XLEN)) decode_i (
        .instr_i    (f_instr),
        .rs1_o      (d_rs1),
        .rs2_o      (d_rs2),
        .rd_o       (d_rd),
        .imm_o      (d_imm),
        .ua_o       (d_ua),
        .inv_cond_o (d_inv)
    );

    useq_urom urom_i (
        .addr_i (upc),
        .word_o (rom_word)
    );

    useq_exec #(.XLEN(XLEN), .PC_W(PC_W)) exec_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dv_i       (f_dv),
        .dpc_i      (f_ipc),
        .drs1_i     (d_rs1),
        .drs2_i     (d_rs2),
        .drd_i      (d_rd),
        .dimm_i     (d_imm),
        .dua_i      (d_ua),
        .dinv_i     (d_inv),
        .word_i     (rom_word),
        .arr_zero_i (arr_zero),
        .upc_o      (upc),
        .take_o     (take),
        .redir_o    (redir),
        .redir_pc_o (redir_pc),
        .ex_valid_o (ex_valid),
        .ex_pc_o    (ex_pc),
        .ex_rs1_o   (ex_rs1),
        .ex_rs2_o   (ex_rs2),
        .ex_rd_o    (ex_rd),
        .ex_imm_o   (ex_imm),
        .ex_inv_o   (x_inv),
        .ex_ctl_o   (ctl_word)
    );

    assign ex_ctl = ctl_word;

endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk
    import useq_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] imem_addr,
    input logic            arr_zero,
    input logic            ex_valid,
    input logic [PC_W-1:0] ex_pc,
    input logic [XLEN-1:0] ex_imm,
    input logic [CW_W-1:0] ex_ctl,
    input logic            dv_i,
    input logic            inv_i,
    input logic            redir_i
);

    logic [2:0]      run_q;
    logic [PC_W-1:0] tgt;
    logic            br_taken;

    assign tgt      = ex_pc + PC_W'(ex_imm);
    assign br_taken = ex_valid && ex_ctl[BR_BIT] && (arr_zero ^ inv_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (ex_valid && !ex_ctl[LAST_BIT]) begin
            run_q <= run_q + 3'd1;
        end else begin
            run_q <= '0;
        end
    end

    // R9
    idle_ctl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> (ex_ctl == '0));

    // R9
    ctl_fields_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |-> ($onehot0(ex_ctl[3:0]) && $onehot0(ex_ctl[6:4]) && $onehot0(ex_ctl[8:7])));

    // R4
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |-> (run_q < 3'd4));

    // R2
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_ctl[LAST_BIT] && dv_i) |=> $stable(imem_addr));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_ctl[LAST_BIT] && dv_i && !redir_i) |=> ex_valid);

    // R8
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> ((imem_addr == $past(tgt)) && !ex_valid));

endmodule

bind useq_core useq_core_chk #(.XLEN(XLEN), .PC_W(PC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .arr_zero  (arr_zero),
    .ex_valid  (ex_valid),
    .ex_pc     (ex_pc),
    .ex_imm    (ex_imm),
    .ex_ctl    (ex_ctl),
    .dv_i      (f_dv),
    .inv_i     (x_inv),
    .redir_i   (redir)
);

// File: tb/useq_core_tb_top.sv
module useq_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arr_zero = 1'b0;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata;
    logic        ex_valid;
    logic [31:0] ex_pc;
    logic [4:0]  ex_rs1, ex_rs2, ex_rd;
    logic [31:0] ex_imm;
    logic [13:0] ex_ctl;

    logic [31:0] mem [64];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] ADD_W = 32'h002081B3;

    typedef struct packed {
        logic [31:0] ins;
        logic        z;
        logic [2:0]  steps;
        logic [13:0] w0;
        logic [13:0] wl;
        logic [4:0]  rd;
        logic [31:0] imm;
        logic [7:0]  npc;
        logic [1:0]  gap;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{32'h002081B3, 1'b1, 3'd1, 14'h1091, 14'h1091, 5'd3,  32'h00000002, 8'd4,  2'd1}, // ADD
        '{32'h402081B3, 1'b1, 3'd3, 14'h2311, 14'h10C1, 5'd3,  32'h00000402, 8'd4,  2'd1}, // SUB
        '{32'h0020C1B3, 1'b1, 3'd1, 14'h1092, 14'h1092, 5'd3,  32'h00000002, 8'd4,  2'd1}, // XOR
        '{32'h0020E1B3, 1'b1, 3'd1, 14'h1098, 14'h1098, 5'd3,  32'h00000002, 8'd4,  2'd1}, // OR
        '{32'h0020F1B3, 1'b1, 3'd1, 14'h1094, 14'h1094, 5'd3,  32'h00000002, 8'd4,  2'd1}, // AND
        '{32'hFFF08293, 1'b1, 3'd1, 14'h10A1, 14'h10A1, 5'd5,  32'hFFFFFFFF, 8'd4,  2'd1}, // ADDI -1
        '{32'h7FF0C293, 1'b1, 3'd1, 14'h10A2, 14'h10A2, 5'd5,  32'h000007FF, 8'd4,  2'd1}, // XORI
        '{32'h1230F293, 1'b1, 3'd1, 14'h10A4, 14'h10A4, 5'd5,  32'h00000123, 8'd4,  2'd1}, // ANDI
        '{32'h8000E293, 1'b1, 3'd1, 14'h10A8, 14'h10A8, 5'd5,  32'hFFFFF800, 8'd4,  2'd1}, // ORI
        '{32'hABCDE3B7, 1'b1, 3'd1, 14'h30A1, 14'h30A1, 5'd7,  32'hABCDE000, 8'd4,  2'd1}, // LUI
        '{32'h002091B3, 1'b1, 3'd1, 14'h1000, 14'h1000, 5'd3,  32'h00000002, 8'd4,  2'd1}, // shift: NOP
        '{32'h0000007F, 1'b1, 3'd1, 14'h1000, 14'h1000, 5'd0,  32'h00000000, 8'd4,  2'd1}, // bad opcode
        '{32'h0020A863, 1'b1, 3'd1, 14'h1000, 14'h1000, 5'd16, 32'h00000010, 8'd4,  2'd1}, // bad branch f3
        '{32'h80208833, 1'b1, 3'd1, 14'h1000, 14'h1000, 5'd16, 32'hFFFFF802, 8'd4,  2'd1}, // bad funct7
        '{32'h00208863, 1'b1, 3'd4, 14'h0112, 14'h3848, 5'd16, 32'h00000010, 8'd16, 2'd3}, // BEQ taken
        '{32'h00208863, 1'b0, 3'd4, 14'h0112, 14'h3848, 5'd16, 32'h00000010, 8'd4,  2'd1}, // BEQ not
        '{32'h00209863, 1'b0, 3'd4, 14'h0112, 14'h3848, 5'd16, 32'h00000010, 8'd16, 2'd3}, // BNE taken
        '{32'h00209863, 1'b1, 3'd4, 14'h0112, 14'h3848, 5'd16, 32'h00000010, 8'd4,  2'd1}  // BNE not
    };

    assign imem_rdata = mem[imem_addr[7:2]];

    always #4 clk = ~clk;

    useq_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .arr_zero   (arr_zero),
        .ex_valid   (ex_valid),
        .ex_pc      (ex_pc),
        .ex_rs1     (ex_rs1),
        .ex_rs2     (ex_rs2),
        .ex_rd      (ex_rd),
        .ex_imm     (ex_imm),
        .ex_ctl     (ex_ctl)
    );

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_exec();
        for (int k = 0; k < 10 && !ex_valid; k++) @(negedge clk);
    endtask

    task automatic run_vec(input int i);
        vec_t        v;
        int          steps;
        int          gap;
        logic [13:0] w0;
        logic [13:0] wl;
        v = VECS[i];
        for (int k = 0; k < 64; k++) mem[k] = '0;
        mem[0]   = v.ins;
        mem[1]   = ADD_W;
        arr_zero = v.z;
        do_reset();
        wait_exec();
        chk_eq($sformatf("R1 vec%0d first pc", i), ex_pc, 32'd0);
        steps = 0;
        w0 = '0;
        wl = '0;
        for (int k = 0; k < 8; k++) begin
            steps++;
            if (k == 0) begin
                w0 = ex_ctl;
                chk_eq($sformatf("R3 vec%0d rd", i), {27'd0, ex_rd}, {27'd0, v.rd});
                chk_eq($sformatf("R3 vec%0d imm", i), ex_imm, v.imm);
            end
            chk_eq($sformatf("R2 vec%0d fetch held", i), imem_addr, 32'd8);
            wl = ex_ctl;
            if (ex_ctl[12]) break;
            @(negedge clk);
        end
        chk_eq($sformatf("R4 vec%0d steps", i), steps, {29'd0, v.steps});
        chk_eq($sformatf("R5 R7 vec%0d first word", i), {18'd0, w0}, {18'd0, v.w0});
        chk_eq($sformatf("R5 R7 vec%0d last word", i), {18'd0, wl}, {18'd0, v.wl});
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
            if (!ex_valid) chk_eq($sformatf("R9 vec%0d idle word", i), {18'd0, ex_ctl}, 32'd0);
        end while (!ex_valid && gap < 8);
        chk_eq($sformatf("R6 R8 vec%0d gap", i), gap, {30'd0, v.gap});
        chk_eq($sformatf("R6 R8 vec%0d next pc", i), ex_pc, {24'd0, v.npc});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 64; k++) mem[k] = ADD_W;
        // R1: state while held in reset
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_eq("R1 reset addr", imem_addr, 32'd0);
        chk_eq("R1 reset valid", {31'd0, ex_valid}, 32'd0);
        chk_eq("R1 reset word", {18'd0, ex_ctl}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R6 R10: back-to-back single-step issue, zero input toggling
        for (int k = 0; k < 64; k++) mem[k] = ADD_W;
        do_reset();
        wait_exec();
        for (int k = 0; k < 6; k++) begin
            chk_eq("R6 R10 stream pc", ex_pc, 32'(4 * k));
            chk_eq("R6 R10 stream valid", {31'd0, ex_valid}, 32'd1);
            arr_zero = ~arr_zero;
            @(negedge clk);
        end

        // R2: fetch address while a three-step subtract runs after an add
        for (int k = 0; k < 64; k++) mem[k] = '0;
        mem[0] = ADD_W;
        mem[1] = 32'h402081B3;
        do_reset();
        wait_exec();
        @(negedge clk);
        chk_eq("R2 sub pc", ex_pc, 32'd4);
        for (int k = 0; k < 3; k++) begin
            chk_eq("R2 sub held addr", imem_addr, 32'd12);
            @(negedge clk);
        end
        chk_eq("R2 R6 after sub pc", ex_pc, 32'd8);
        chk_eq("R2 after sub addr", imem_addr, 32'd16);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule